// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A clocked, single-port memory with byte-lane writes, a registered access address and a two-bit burst counter. A new access starts when either of two load strobes is asserted low while the three chip enables are all active. The CPU-side strobe only counts when the main enable is active. The controller-side strobe always counts. When it arrives with any enable inactive, the device deselects. With no strobe present, a low step input moves the burst to the next word of the four-word group. A high step input holds the current word. A static ordering pin picks either a linear order that wraps modulo 4 or an XOR-interleaved order.

Writes are selected in two levels. A global write strobe writes every lane. Failing that, a lane-write qualifier lets each lane's own select write that lane alone. In every other case the access is a read. Read data appears either in the cycle after the access edge (flow-through) or one cycle later (pipelined), chosen by a static pin. The output drive enable is gated asynchronously by an output-enable input and by the sleep input. While sleep is high, all accesses are ignored and the stored contents are kept. Write data and read data use separate buses, and a drive enable stands in for the bidirectional pads.

Top module: `burst_sram`

## Requirements
- R1: An edge with `ctl_ld_n` low and all enables active (`en_main_n`=0, `en_hi`=1, `en_lo_n`=0) loads `addr`. The upper bits form the group base and `addr[1:0]` becomes the start offset. The burst count is cleared and the device is selected.
- R2: With `en_main_n` low and the other enables active, `cpu_ld_n` low also loads as in R1. With `en_main_n` high, `cpu_ld_n` is ignored: without a controller strobe, the edge behaves as a step or a hold.
- R3: A strobe that counts (controller strobe, or CPU strobe with the main enable active) while any enable is inactive deselects the device. A deselected device neither writes nor drives read data until the next load.
- R4: On an edge with no counting strobe and the device selected, `step_n` low increments the two-bit count. `step_n` high leaves the count, and with it the access address, unchanged. A strobe takes priority over a step.
- R5: The access address is {base, offset}. The offset is start XOR count when `seq_xor`=1, and (start + count) mod 4 when `seq_xor`=0. The base never changes during a burst.
- R6: `wr_all_n` low writes all lanes of the access word.
- R7: With `wr_all_n` high and `lane_wr_n` low, lane i (bits 8i+7:8i) is written exactly when `lane_sel_n[i]` is low. The other lanes keep their contents.
- R8: With `wr_all_n` high, the access is a read when `lane_wr_n` is high or every `lane_sel_n` bit is high, and the memory is not changed.
- R9: With `pipe_mode`=0, data of a read at edge k is driven between edges k and k+1. With `pipe_mode`=1, it is driven between edges k+1 and k+2.
- R10: `rdata_oe` is high only when `out_en_n` is low and the cycle being presented is a read. `out_en_n` acts on the output without waiting for a clock edge.
- R11: While `sleep` is high, edges change neither the address state nor the memory, and `rdata_oe` is low. Operation resumes at the first edge after `sleep` falls.
- R12: After reset the device is deselected and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address captured on a load |
| en_main_n | input | 1 | Main chip enable, active low; also qualifies the CPU strobe |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_lo_n | input | 1 | Secondary chip enable, active low |
| cpu_ld_n | input | 1 | CPU-side load strobe, active low |
| ctl_ld_n | input | 1 | Controller-side load strobe, active low |
| step_n | input | 1 | Burst step, active low |
| wr_all_n | input | 1 | Global write, active low |
| lane_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_sel_n | input | NB | Per-lane write selects, active low |
| wdata | input | NB*LW | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| pipe_mode | input | 1 | 0 = flow-through, 1 = pipelined read |
| seq_xor | input | 1 | 1 = interleaved order, 0 = linear order |
| sleep | input | 1 | Low-power hold, active high |
| rdata | output | NB*LW | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
The busiest overlaps are a strobe and a step in the same cycle, where the strobe must win, and a CPU strobe while the main enable is high, where the strobe must be ignored and the step or hold must take effect. Random stimulus produces these combinations freely, and directed sequences place them deliberately inside bursts. A bench reference model tracks base, start, count and the memory image. It predicts the drive enable and the data on every cycle, so a step that is wrongly taken or lost shows up as wrong read data in a later cycle of the same burst.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // offset within the four-word group for a given start and count
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] cnt,
                                              input logic       xor_order);
    logic [1:0] lin;
    lin = start + cnt;
    return xor_order ? (start ^ cnt) : lin;
  endfunction

endpackage

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl
  import burst_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [AW-1:0] addr,
  input  logic          en_main_n,
  input  logic          en_hi,
  input  logic          en_lo_n,
  input  logic          cpu_ld_n,
  input  logic          ctl_ld_n,
  input  logic          step_n,
  input  logic          seq_xor,
  output logic [AW-1:0] acc_addr,
  output logic          acc_sel
);
  localparam int UW = AW - 2;

  logic          sel_r, sel_n;
  logic [UW-1:0] base_r, base_n;
  logic [1:0]    start_r, start_n;
  logic [1:0]    cnt_r, cnt_n;

  // named events for the checks
  logic ctl_strobe, cpu_strobe, any_strobe, enables_ok;
  logic load_evt, desel_evt, step_evt;

  assign ctl_strobe = !ctl_ld_n;
  assign cpu_strobe = !cpu_ld_n && !en_main_n;
  assign any_strobe = ctl_strobe || cpu_strobe;
  assign enables_ok = !en_main_n && en_hi && !en_lo_n;
  assign load_evt   = any_strobe && enables_ok;
  assign desel_evt  = any_strobe && !enables_ok;
  assign step_evt   = !any_strobe && sel_r && !step_n;

  always_comb begin
    sel_n   = sel_r;
    base_n  = base_r;
    start_n = start_r;
    cnt_n   = cnt_r;
    if (load_evt) begin
      sel_n   = 1'b1;
      base_n  = addr[AW-1:2];
      start_n = addr[1:0];
      cnt_n   = 2'd0;
    end else if (desel_evt) begin
      sel_n = 1'b0;
    end else if (step_evt) begin
      cnt_n = cnt_r + 2'd1;
    end
  end

  assign acc_addr = {base_n, burst_offset(start_n, cnt_n, seq_xor)};
  assign acc_sel  = sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_r   <= 1'b0;
      base_r  <= '0;
      start_r <= 2'd0;
      cnt_r   <= 2'd0;
    end else if (!hold) begin
      sel_r   <= sel_n;
      base_r  <= base_n;
      start_r <= start_n;
      cnt_r   <= cnt_n;
    end
  end

  // R2: the CPU strobe with the main enable off must not load or deselect
  p_cpu_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !cpu_ld_n && en_main_n && ctl_ld_n) |=>
      ($stable(sel_r) && $stable(base_r) && $stable(start_r)));

  // R3: a controller strobe with the active-high enable off deselects
  p_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !ctl_ld_n && !en_hi) |=> !sel_r);

  // R4: a step moves the count by one
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && step_evt) |=> (cnt_r == $past(cnt_r) + 2'd1));

  // R4: no strobe and no step keeps the address
  p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && ctl_ld_n && (cpu_ld_n || en_main_n) && step_n) |=>
      ($stable(cnt_r) && $stable(base_r) && $stable(start_r)));

  // R1: a load always clears the count
  p_load_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && load_evt) |=> (cnt_r == 2'd0 && sel_r));

  // R11: sleep freezes the address state
  p_sleep_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(sel_r) && $stable(cnt_r) && $stable(base_r)));

endmodule

// File: rtl/burst_write_dec.sv
module burst_write_dec
  import burst_sram_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          wr_all_n,
  input  logic          lane_wr_n,
  input  logic [NB-1:0] lane_sel_n,
  input  logic          acc_sel,
  output logic [NB-1:0] lane_we,
  output acc_kind_e     acc_kind
);

  // two-level write enable: global first, then qualified per-lane selects
  function automatic logic [NB-1:0] lane_mask(input logic          all_n,
                                              input logic          qual_n,
                                              input logic [NB-1:0] sel_n);
    if (!all_n)  return {NB{1'b1}};
    if (!qual_n) return ~sel_n;
    return '0;
  endfunction

  logic [NB-1:0] raw_mask;

  assign raw_mask = lane_mask(wr_all_n, lane_wr_n, lane_sel_n);
  assign lane_we  = acc_sel ? raw_mask : '0;

  always_comb begin
    if (!acc_sel)      acc_kind = ACC_IDLE;
    else if (|lane_we) acc_kind = ACC_WRITE;
    else               acc_kind = ACC_READ;
  end

  always_comb begin
    if (acc_sel && !wr_all_n) begin
      p_all_lanes_r6: assert (&lane_we);
    end
    if (acc_sel && wr_all_n && (lane_wr_n || (&lane_sel_n))) begin
      p_read_case_r8: assert (acc_kind == ACC_READ);
    end
  end

endmodule

// File: rtl/burst_array.sv
module burst_array
  import burst_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [AW-1:0]    acc_addr,
  input  acc_kind_e        acc_kind,
  input  logic [NB-1:0]    lane_we,
  input  logic [NB*LW-1:0] wdata,
  input  logic             pipe_mode,
  input  logic             out_en_n,
  output logic [NB*LW-1:0] rdata,
  output logic             rdata_oe
);
  localparam int DW    = NB * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] cur_word, merged;
  logic [AW-1:0] addr_q;
  logic          rd1_q, rd2_q;
  logic [DW-1:0] pipe_q;
  logic [DW-1:0] flow_data, data_now;
  logic          rd_now;
  logic          wr_evt;

  assign cur_word = mem[acc_addr];
  assign wr_evt   = !hold && (|lane_we);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign merged[g*LW +: LW] = lane_we[g] ? wdata[g*LW +: LW]
                                           : cur_word[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (wr_evt) mem[acc_addr] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd1_q  <= 1'b0;
      rd2_q  <= 1'b0;
      pipe_q <= '0;
    end else if (!hold) begin
      addr_q <= acc_addr;
      rd1_q  <= (acc_kind == ACC_READ);
      rd2_q  <= rd1_q;
      pipe_q <= mem[addr_q];
    end
  end

  assign flow_data = mem[addr_q];
  assign rd_now    = pipe_mode ? rd2_q : rd1_q;
  assign data_now  = pipe_mode ? pipe_q : flow_data;
  assign rdata_oe  = rd_now && !out_en_n && !hold;
  assign rdata     = rdata_oe ? data_now : '0;

  // R9: flow-through drive follows a read edge one cycle back
  p_flow_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && !pipe_mode && $past(!hold)) |->
      $past(acc_kind == ACC_READ));

  // R9: pipelined drive follows a read edge two cycles back
  p_pipe_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe && pipe_mode && $past(!hold) && $past(!hold, 2)) |->
      $past(acc_kind == ACC_READ, 2));

  // R10: no drive without the output enable
  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_oe);

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int LW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             en_main_n,
  input  logic             en_hi,
  input  logic             en_lo_n,
  input  logic             cpu_ld_n,
  input  logic             ctl_ld_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             lane_wr_n,
  input  logic [NB-1:0]    lane_sel_n,
  input  logic [NB*LW-1:0] wdata,
  input  logic             out_en_n,
  input  logic             pipe_mode,
  input  logic             seq_xor,
  input  logic             sleep,
  output logic [NB*LW-1:0] rdata,
  output logic             rdata_oe
);
  logic [AW-1:0] acc_addr;
  logic          acc_sel;
  logic [NB-1:0] lane_we;
  acc_kind_e     acc_kind;

  burst_addr_ctl #(.AW(AW)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (sleep),
    .addr      (addr),
    .en_main_n (en_main_n),
    .en_hi     (en_hi),
    .en_lo_n   (en_lo_n),
    .cpu_ld_n  (cpu_ld_n),
    .ctl_ld_n  (ctl_ld_n),
    .step_n    (step_n),
    .seq_xor   (seq_xor),
    .acc_addr  (acc_addr),
    .acc_sel   (acc_sel)
  );

  burst_write_dec #(.NB(NB)) u_wdec (
    .wr_all_n   (wr_all_n),
    .lane_wr_n  (lane_wr_n),
    .lane_sel_n (lane_sel_n),
    .acc_sel    (acc_sel),
    .lane_we    (lane_we),
    .acc_kind   (acc_kind)
  );

  burst_array #(.AW(AW), .NB(NB), .LW(LW)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (sleep),
    .acc_addr  (acc_addr),
    .acc_kind  (acc_kind),
    .lane_we   (lane_we),
    .wdata     (wdata),
    .pipe_mode (pipe_mode),
    .out_en_n  (out_en_n),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe)
  );

  // R11: nothing is driven while asleep
  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_oe);

  // R12: the first edge after reset presents no read
  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rdata_oe);

endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int LW = 8;
  localparam int DW = NB * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic en_main_n = 1'b0, en_hi = 1'b1, en_lo_n = 1'b0;
  logic cpu_ld_n = 1'b1, ctl_ld_n = 1'b1, step_n = 1'b1;
  logic wr_all_n = 1'b1, lane_wr_n = 1'b1;
  logic [NB-1:0] lane_sel_n = '1;
  logic [DW-1:0] wdata = '0;
  logic out_en_n = 1'b0, pipe_mode = 1'b0, seq_xor = 1'b1, sleep = 1'b0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int nchk = 0;
  int nerr = 0;

  // reference model state
  logic          m_sel = 1'b0;
  int            m_base = 0, m_start = 0, m_cnt = 0;
  logic [DW-1:0] m_mem [DEPTH];
  logic          m_rd1 = 1'b0, m_rd2 = 1'b0;
  logic [DW-1:0] m_d1 = '0, m_d2 = '0;

  always #(CLK_P/2) clk = ~clk;

  burst_sram #(.AW(AW), .NB(NB), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .en_main_n(en_main_n),
    .en_hi(en_hi), .en_lo_n(en_lo_n), .cpu_ld_n(cpu_ld_n),
    .ctl_ld_n(ctl_ld_n), .step_n(step_n), .wr_all_n(wr_all_n),
    .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .wdata(wdata),
    .out_en_n(out_en_n), .pipe_mode(pipe_mode), .seq_xor(seq_xor),
    .sleep(sleep), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // order rule written independently: interleaved flips bits, linear adds
  function automatic int order_pos(int s, int c, logic x);
    if (x) return s ^ c;
    return (s + c) % 4;
  endfunction

  task automatic model_edge();
    logic ctl_s, cpu_s, ok;
    logic [NB-1:0] we;
    int a;
    if (sleep) return;
    ctl_s = !ctl_ld_n;
    cpu_s = !cpu_ld_n && !en_main_n;
    ok = !en_main_n && en_hi && !en_lo_n;
    if (ctl_s || cpu_s) begin
      if (ok) begin
        m_sel = 1'b1; m_base = int'(addr) / 4; m_start = int'(addr) % 4; m_cnt = 0;
      end else m_sel = 1'b0;
    end else if (m_sel && !step_n) m_cnt = (m_cnt + 1) % 4;
    a = m_base * 4 + order_pos(m_start, m_cnt, seq_xor);
    we = '0;
    if (m_sel) begin
      if (!wr_all_n) we = '1;
      else if (!lane_wr_n) we = ~lane_sel_n;
    end
    for (int i = 0; i < NB; i++)
      if (we[i]) m_mem[a][i*LW +: LW] = wdata[i*LW +: LW];
    m_rd2 = m_rd1; m_d2 = m_d1;
    m_rd1 = m_sel && (we == '0);
    m_d1 = m_mem[a];
  endtask

  task automatic check_out(input string tag);
    logic eo;
    logic [DW-1:0] ed;
    eo = !sleep && !out_en_n && (pipe_mode ? m_rd2 : m_rd1);
    ed = pipe_mode ? m_d2 : m_d1;
    nchk++;
    if (rdata_oe !== eo || (eo && rdata !== ed)) begin
      nerr++;
      $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h", tag,
               rdata_oe, rdata, eo, ed);
    end
  endtask

  task automatic tick(input string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic idle();
    cpu_ld_n = 1'b1; ctl_ld_n = 1'b1; step_n = 1'b1;
    wr_all_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = '1;
    en_main_n = 1'b0; en_hi = 1'b1; en_lo_n = 1'b0;
    out_en_n = 1'b0; sleep = 1'b0;
  endtask

  task automatic ctl_read(input int a, input string tag);
    idle(); addr = AW'(a); ctl_ld_n = 1'b0; tick(tag);
  endtask

  task automatic step_read(input string tag);
    idle(); step_n = 1'b0; tick(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    idle();
    @(negedge clk); @(negedge clk);
    // R12: reset state
    nchk++;
    if (rdata_oe !== 1'b0) begin
      nerr++; $display("FAIL R12: oe=%0b expected oe=0", rdata_oe);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle(); tick("R12");

    // R6: fill every word through the global write
    for (int i = 0; i < DEPTH; i++) begin
      idle(); addr = AW'(i); ctl_ld_n = 1'b0; wr_all_n = 1'b0; out_en_n = 1'b1;
      wdata = $urandom(); tick("R6");
    end

    // R5/R4: linear burst from offset 2, then a hold, flow-through
    seq_xor = 1'b0;
    ctl_read(6'h0A, "R5");
    step_read("R5"); step_read("R4");
    idle(); tick("R4");
    step_read("R5");
    // R5: interleaved burst from offset 1
    seq_xor = 1'b1;
    ctl_read(6'h15, "R5");
    for (int k = 0; k < 3; k++) step_read("R5");

    // R7: lane writes, then read back
    idle(); addr = 6'h20; ctl_ld_n = 1'b0; lane_wr_n = 1'b0; lane_sel_n = 4'b1010;
    out_en_n = 1'b1; wdata = 32'hA1B2C3D4; tick("R7");
    ctl_read(6'h20, "R7");
    // R8: qualifier low with no lane selected, and lane selects without qualifier
    idle(); addr = 6'h20; ctl_ld_n = 1'b0; lane_wr_n = 1'b0; lane_sel_n = 4'b1111;
    wdata = 32'hFFFF_FFFF; tick("R8");
    idle(); addr = 6'h20; ctl_ld_n = 1'b0; lane_sel_n = 4'b0000;
    wdata = 32'h0; tick("R8");
    ctl_read(6'h20, "R8");

    // R2: CPU strobe blocked with main enable high, step in same cycle
    ctl_read(6'h30, "R2");
    idle(); en_main_n = 1'b1; cpu_ld_n = 1'b0; addr = 6'h04; step_n = 1'b0; tick("R2");
    idle(); en_main_n = 1'b1; cpu_ld_n = 1'b0; addr = 6'h08; tick("R2");
    idle(); cpu_ld_n = 1'b0; addr = 6'h05; tick("R2");
    // R1: strobe wins over a step in the same cycle
    idle(); ctl_ld_n = 1'b0; step_n = 1'b0; addr = 6'h2E; tick("R1");

    // R3: deselect, then attempted writes and reads do nothing
    idle(); ctl_ld_n = 1'b0; en_hi = 1'b0; tick("R3");
    idle(); step_n = 1'b0; wr_all_n = 1'b0; out_en_n = 1'b1; wdata = 32'h0; tick("R3");
    idle(); step_n = 1'b0; tick("R3");
    idle(); cpu_ld_n = 1'b0; en_lo_n = 1'b1; tick("R3");
    ctl_read(6'h2E, "R3");

    // R9: pipelined reads
    pipe_mode = 1'b1;
    ctl_read(6'h11, "R9");
    step_read("R9"); step_read("R9");
    idle(); tick("R9"); idle(); tick("R9");
    pipe_mode = 1'b0;

    // R10: output enable acts between edges
    ctl_read(6'h03, "R10");
    out_en_n = 1'b1; #1;
    nchk++;
    if (rdata_oe !== 1'b0) begin
      nerr++; $display("FAIL R10: oe=%0b expected oe=0", rdata_oe);
    end
    out_en_n = 1'b0; #1;
    nchk++;
    if (rdata_oe !== 1'b1 || rdata !== m_d1) begin
      nerr++; $display("FAIL R10: oe=%0b data=%h expected oe=1 data=%h",
                       rdata_oe, rdata, m_d1);
    end

    // R11: sleep ignores a write strobe, then operation resumes
    idle(); sleep = 1'b1; addr = 6'h03; ctl_ld_n = 1'b0; wr_all_n = 1'b0;
    wdata = 32'hDEAD_BEEF; tick("R11");
    idle(); sleep = 1'b1; step_n = 1'b0; tick("R11");
    idle(); tick("R11");
    ctl_read(6'h03, "R11");

    // R1: constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      r = int'($urandom() % 16);
      addr = AW'($urandom());
      if (r < 5) begin
        ctl_ld_n = 1'b0;
        if ($urandom() % 5 == 0) begin
          en_hi = 1'($urandom()); en_lo_n = 1'($urandom()); en_main_n = 1'($urandom());
        end
      end else if (r < 7) begin
        cpu_ld_n = 1'b0; en_main_n = ($urandom() % 4 == 0);
        if ($urandom() % 6 == 0) en_hi = 1'b0;
      end else if (r < 12) step_n = 1'b0;
      else if (r == 14) sleep = 1'b1;
      else if (r == 15) begin ctl_ld_n = 1'b0; en_lo_n = 1'b1; end
      step_n = (r < 12 && r >= 7) ? 1'b0 : 1'($urandom());
      if ($urandom() % 5 < 2) begin
        out_en_n = 1'b1; wdata = $urandom();
        if ($urandom() % 3 == 0) wr_all_n = 1'b0;
        else begin lane_wr_n = 1'b0; lane_sel_n = NB'($urandom()); end
      end else begin
        out_en_n = ($urandom() % 5 == 0);
        lane_sel_n = NB'($urandom()); lane_wr_n = ($urandom() % 2 == 0) ? 1'b1 : 1'b0;
        if (!lane_wr_n) lane_sel_n = '1;
      end
      if ($urandom() % 50 == 0) seq_xor = ~seq_xor;
      if ($urandom() % 200 == 0) pipe_mode = ~pipe_mode;
      tick("R1");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule